// File: doc/BRIEF.md
# Dual-Compare Timer with PWM Modes

A 10-bit up-counter with two comparators, driving one output pin and two sticky interrupt flags. Comparator A checks the whole count against a 10-bit compare value. Comparator P checks the top three count bits against a 3-bit period value, so the period is a multiple of 128 counts. A control bit picks which comparator clears the counter. A 2-bit mode field picks one of three pin behaviours: compare-match output, PWM, or plain timer/counter, in which the pin is left alone.

The host reaches the block through a byte-wide register port. Reads are combinational on `rdata_o`. Writes take effect at the clock edge while `wr_en_i` is high. Wider values are split into a low byte and a high byte. The counter read is made coherent by a shadow register. The compare A write is made atomic by a holding buffer. The counter advances once per clock while the run bit is set.

Top module: `dual_cmp_timer`

Register map (addr_i): 0 = control (bit0 run, bits 3:1 period), 1 = config (bits 1:0 mode, bits 3:2 output action, bit4 clear-on-A), 2 = count low, 3 = count high, 4 = compare A low, 5 = compare A high, 6 = flags (bit0 A, bit1 P, write 1 to clear). Unlisted bits and address 7 read as zero.

## Requirements
- R1: After reset, every register reads 0, and `pin_o`, `flag_a_o` and `flag_p_o` are 0.
- R2: While run (addr 0 bit0) is 1, the count rises by one per clock, starting from 0 at the edge after run is written. Writing run to 0 holds the count at 0.
- R3: With clear-on-A (addr 1 bit4) at 0 and period value p, the count goes back to 0 after it reaches p*128-1. The period is therefore p*128 clocks. A period value of 0 gives a full 1024-count wrap.
- R4: With clear-on-A at 1 and compare value a, the count goes back to 0 after it reaches a, giving a period of a+1. A comparator P match does not clear the count in this setting.
- R5: When the running count equals the compare value, flag A (addr 6 bit0, `flag_a_o`) is set one clock later. When the running count equals p*128-1 (1023 for p=0), flag P (bit1, `flag_p_o`) is set one clock later. Each flag stays set, in any mode, until a 1 is written to its own bit.
- R6: A write to compare A low (addr 4) goes only to a holding buffer. The compare value is unchanged until addr 5 is written, which loads its bits 1:0 together with the buffer.
- R7: Reading count low (addr 2 with `rd_en_i`) captures count bits 9:8. A later read of addr 3 returns that captured pair, not the live bits. Bits 7:2 of addr 3 and addr 5 read as 0.
- R8: In mode 00, a comparator A match acts on the pin one clock later, as selected by addr 1 bits 3:2: 00 no change, 01 drive 0, 10 drive 1, 11 invert.
- R9: In mode 01, while running, `pin_o` is 1 exactly while the count is below the compare value. It is 0 whenever run is 0.
- R10: In modes 10 and 11, `pin_o` holds its value while the counter runs and the flags are still raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe for the current cycle |
| rd_en_i | input | 1 | Read strobe; a read of count low captures the high bits |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| pin_o | output | 1 | Timer output pin |
| flag_a_o | output | 1 | Sticky comparator A flag |
| flag_p_o | output | 1 | Sticky comparator P flag |

## Verification
The PWM assertion assumes the compare value and the mode stay steady while the count is live. For that reason the bench changes the mode, the compare value and the clear select only while run is 0. The bus assertions assume one access per cycle, with the strobes and the address steady around each edge. The stimulus meets this by driving every bus access on the falling edge and allowing one access per cycle.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DW     = 8;

  typedef enum logic [1:0] {
    MD_CMP  = 2'b00,
    MD_PWM  = 2'b01,
    MD_TMR  = 2'b10,
    MD_TMR2 = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    OC_NONE = 2'b00,
    OC_LOW  = 2'b01,
    OC_HIGH = 2'b10,
    OC_TOG  = 2'b11
  } oc_e;

  localparam logic [ADDR_W-1:0] A_CTRL0  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL1  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd5;
  localparam logic [ADDR_W-1:0] A_FLAG   = 3'd6;
endpackage

// File: rtl/dct_regs.sv
module dct_regs
  import dct_pkg::*;
#(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned PRD_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              set_a_i,
  input  logic              set_p_i,
  output logic              run_o,
  output logic              run_d_o,
  output logic [PRD_W-1:0]  prd_o,
  output mode_e             mode_o,
  output oc_e               oc_o,
  output logic              csel_o,
  output logic [CNT_W-1:0]  cmpa_o,
  output logic              flag_a_o,
  output logic              flag_p_o
);
  localparam int unsigned HI_W  = CNT_W - DW;
  localparam int unsigned PAD_H = DW - HI_W;
  localparam int unsigned PAD_C = DW - 1 - PRD_W;

  logic              run_q, csel_q, flag_a_q, flag_p_q;
  logic [PRD_W-1:0]  prd_q;
  mode_e             mode_q;
  oc_e               oc_q;
  logic [DW-1:0]     cmp_buf_q;
  logic [CNT_W-1:0]  cmpa_q;
  logic [HI_W-1:0]   shadow_q;

  logic wr_c0, wr_c1, wr_clo, wr_chi, wr_fl, rd_lo;
  assign wr_c0  = wr_en_i && (addr_i == A_CTRL0);
  assign wr_c1  = wr_en_i && (addr_i == A_CTRL1);
  assign wr_clo = wr_en_i && (addr_i == A_CMP_LO);
  assign wr_chi = wr_en_i && (addr_i == A_CMP_HI);
  assign wr_fl  = wr_en_i && (addr_i == A_FLAG);
  assign rd_lo  = rd_en_i && (addr_i == A_CNT_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      prd_q     <= '0;
      mode_q    <= MD_CMP;
      oc_q      <= OC_NONE;
      csel_q    <= 1'b0;
      cmp_buf_q <= '0;
      cmpa_q    <= '0;
      shadow_q  <= '0;
      flag_a_q  <= 1'b0;
      flag_p_q  <= 1'b0;
    end else begin
      if (wr_c0) begin
        run_q <= wdata_i[0];
        prd_q <= wdata_i[PRD_W:1];
      end
      if (wr_c1) begin
        mode_q <= mode_e'(wdata_i[1:0]);
        oc_q   <= oc_e'(wdata_i[3:2]);
        csel_q <= wdata_i[4];
      end
      if (wr_clo) cmp_buf_q <= wdata_i;
      // full compare value moves only on high-byte write
      if (wr_chi) cmpa_q <= {wdata_i[HI_W-1:0], cmp_buf_q};
      if (rd_lo)  shadow_q <= cnt_i[CNT_W-1:DW];
      // set wins over write-1-to-clear
      if (set_a_i)                 flag_a_q <= 1'b1;
      else if (wr_fl && wdata_i[0]) flag_a_q <= 1'b0;
      if (set_p_i)                 flag_p_q <= 1'b1;
      else if (wr_fl && wdata_i[1]) flag_p_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL0:  rdata_o = {{PAD_C{1'b0}}, prd_q, run_q};
      A_CTRL1:  rdata_o = {3'b000, csel_q, oc_q, mode_q};
      A_CNT_LO: rdata_o = cnt_i[DW-1:0];
      A_CNT_HI: rdata_o = {{PAD_H{1'b0}}, shadow_q};
      A_CMP_LO: rdata_o = cmpa_q[DW-1:0];
      A_CMP_HI: rdata_o = {{PAD_H{1'b0}}, cmpa_q[CNT_W-1:DW]};
      A_FLAG:   rdata_o = {{(DW-2){1'b0}}, flag_p_q, flag_a_q};
      default:  rdata_o = '0;
    endcase
  end

  assign run_o    = run_q;
  assign run_d_o  = wr_c0 ? wdata_i[0] : run_q;
  assign prd_o    = prd_q;
  assign mode_o   = mode_q;
  assign oc_o     = oc_q;
  assign csel_o   = csel_q;
  assign cmpa_o   = cmpa_q;
  assign flag_a_o = flag_a_q;
  assign flag_p_o = flag_p_q;

  a_r5_flag_a_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_a_i |=> flag_a_q);
  a_r5_flag_a_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_a_q && !(wr_en_i && addr_i == A_FLAG && wdata_i[0])) |=> flag_a_q);
  a_r5_flag_p_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_p_q && !(wr_en_i && addr_i == A_FLAG && wdata_i[1])) |=> flag_p_q);
  a_r6_cmp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == A_CMP_HI) |=> $stable(cmpa_q));
  a_r7_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && addr_i == A_CNT_LO) |=> $stable(shadow_q));
endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned PRD_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             csel_i,
  input  logic [PRD_W-1:0] prd_i,
  input  logic [CNT_W-1:0] cmpa_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_d_o,
  output logic             hit_a_o,
  output logic             hit_p_o
);
  localparam int unsigned LO_W = CNT_W - PRD_W;
  localparam logic [PRD_W-1:0] PRD_ONE = 1;
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PRD_W-1:0] prd_last;
  logic             hit_a, hit_p, clr;

  // last count of a period: top bits equal period-1 (wraps to all ones for 0)
  assign prd_last = prd_i - PRD_ONE;
  assign hit_a = run_i && (cnt_q == cmpa_i);
  assign hit_p = run_i && (cnt_q[CNT_W-1:LO_W] == prd_last) && (&cnt_q[LO_W-1:0]);
  assign clr   = csel_i ? hit_a : hit_p;

  always_comb begin
    if (!run_i)   cnt_d = '0;
    else if (clr) cnt_d = '0;
    else          cnt_d = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o   = cnt_q;
  assign cnt_d_o = cnt_d;
  assign hit_a_o = hit_a;
  assign hit_p_o = hit_p;

  a_r2_stop_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !hit_a && !hit_p) |=> (cnt_q == $past(cnt_q) + CNT_ONE));
  a_r3_period_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !csel_i && cnt_q == CNT_W'({prd_i, {LO_W{1'b0}}} - CNT_ONE)) |=> (cnt_q == '0));
  a_r4_cmp_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && csel_i && cnt_q == cmpa_i) |=> (cnt_q == '0));
  a_r4_no_p_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && csel_i && cnt_q != cmpa_i && !(&cnt_q)) |=> (cnt_q != '0));
endmodule

// File: rtl/dct_out.sv
module dct_out
  import dct_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_e            mode_i,
  input  oc_e              oc_i,
  input  logic             run_i,
  input  logic             run_d_i,
  input  logic             hit_a_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cnt_d_i,
  input  logic [CNT_W-1:0] cmpa_i,
  output logic             pin_o
);
  logic out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else begin
      case (mode_i)
        MD_CMP: begin
          if (hit_a_i) begin
            case (oc_i)
              OC_LOW:  out_q <= 1'b0;
              OC_HIGH: out_q <= 1'b1;
              OC_TOG:  out_q <= ~out_q;
              default: out_q <= out_q;
            endcase
          end
        end
        // look ahead on count and run so the pin lines up with the count
        MD_PWM:  out_q <= run_d_i && (cnt_d_i < cmpa_i);
        default: out_q <= out_q;
      endcase
    end
  end

  assign pin_o = out_q;

  a_r8_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MD_CMP && oc_i == OC_TOG && hit_a_i) |=> (out_q != $past(out_q)));
  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MD_CMP && !hit_a_i) |=> $stable(out_q));
  a_r9_pwm_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MD_PWM && $past(mode_i) == MD_PWM && run_i && $past(run_i) && $stable(cmpa_i))
      |-> (out_q == (cnt_i < cmpa_i)));
  a_r10_timer_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[1] |=> $stable(out_q));
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import dct_pkg::*;
#(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned PRD_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              pin_o,
  output logic              flag_a_o,
  output logic              flag_p_o
);
  logic             run, run_d, csel, hit_a, hit_p;
  logic [PRD_W-1:0] prd;
  mode_e            mode;
  oc_e              oc;
  logic [CNT_W-1:0] cmpa, cnt, cnt_d;

  dct_regs #(.CNT_W(CNT_W), .PRD_W(PRD_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .cnt_i    (cnt),
    .set_a_i  (hit_a),
    .set_p_i  (hit_p),
    .run_o    (run),
    .run_d_o  (run_d),
    .prd_o    (prd),
    .mode_o   (mode),
    .oc_o     (oc),
    .csel_o   (csel),
    .cmpa_o   (cmpa),
    .flag_a_o (flag_a_o),
    .flag_p_o (flag_p_o)
  );

  dct_counter #(.CNT_W(CNT_W), .PRD_W(PRD_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .csel_i  (csel),
    .prd_i   (prd),
    .cmpa_i  (cmpa),
    .cnt_o   (cnt),
    .cnt_d_o (cnt_d),
    .hit_a_o (hit_a),
    .hit_p_o (hit_p)
  );

  dct_out #(.CNT_W(CNT_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .oc_i    (oc),
    .run_i   (run),
    .run_d_i (run_d),
    .hit_a_i (hit_a),
    .cnt_i   (cnt),
    .cnt_d_i (cnt_d),
    .cmpa_i  (cmpa),
    .pin_o   (pin_o)
  );
endmodule

// File: tb/dual_cmp_timer_tb.sv
module dual_cmp_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pin, flag_a, flag_p;

  int cyc = 0, e_cyc = 0, total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_cmp_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .pin_o(pin), .flag_a_o(flag_a), .flag_p_o(flag_p)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk); addr = a; rd_en = 1'b1; #1; v = rdata; rd_en = 1'b0;
  endtask

  task automatic rd_cnt(output int v, output int m);
    logic [7:0] lo;
    @(negedge clk); addr = 3'd2; rd_en = 1'b1; #1; lo = rdata; m = cyc - e_cyc;
    @(negedge clk); addr = 3'd3; #1; v = {rdata[1:0], lo}; rd_en = 1'b0;
  endtask

  task automatic start(input int prd);
    wr(3'd0, 8'((prd << 1) | 1));
    e_cyc = cyc;
  endtask

  task automatic stop();
    wr(3'd0, 8'h00);
  endtask

  task automatic set_cmp(input int a);
    wr(3'd4, 8'(a & 255));
    wr(3'd5, 8'(a >> 8));
  endtask

  task automatic wait_m(input int m);
    while (cyc - e_cyc < m) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    report();
  end

  initial begin
    int v, m, per;
    int dl[3];
    int av[7];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk($sformatf("R1 reg%0d", a), v, 0);
    end
    chk("R1 pin", pin, 0);
    chk("R1 flags", {flag_p, flag_a}, 0);

    // R2 counting from zero, stop clears
    wr(3'd1, 8'h00);
    start(0);
    rd_cnt(v, m);
    chk("R2 first count", v, m);
    repeat (200) @(negedge clk);
    rd_cnt(v, m);
    chk("R2 count", v, m);
    stop();
    repeat (5) @(negedge clk);
    rd_cnt(v, m);
    chk("R2 stop zero", v, 0);

    // R3 period sweep, clear on P
    dl = '{37, 411, 1283};
    for (int p = 0; p < 8; p++) begin
      per = (p == 0) ? 1024 : p * 128;
      stop();
      start(p);
      foreach (dl[i]) begin
        repeat (dl[i]) @(negedge clk);
        rd_cnt(v, m);
        chk($sformatf("R3 p=%0d", p), v, m % per);
      end
    end
    stop();

    // R4 clear on A, period value 1 would clear at 127
    av = '{0, 1, 5, 127, 128, 300, 1023};
    wr(3'd1, 8'h10);
    foreach (av[k]) begin
      set_cmp(av[k]);
      start(1);
      foreach (dl[i]) begin
        repeat (dl[i] / 3 + 2) @(negedge clk);
        rd_cnt(v, m);
        chk($sformatf("R4 a=%0d", av[k]), v, m % (av[k] + 1));
      end
      stop();
    end

    // R5 flags: A at 50, P at 127 (period value 1), sticky, independent clear
    wr(3'd1, 8'h00);
    set_cmp(50);
    wr(3'd6, 8'h03);
    start(1);
    wait_m(50);  chk("R5 flag_a before", flag_a, 0);
    wait_m(51);  chk("R5 flag_a set", flag_a, 1);
    wait_m(127); chk("R5 flag_p before", flag_p, 0);
    wait_m(128); chk("R5 flag_p set", flag_p, 1);
    wr(3'd6, 8'h01);
    chk("R5 flag_a cleared", flag_a, 0);
    chk("R5 flag_p kept", flag_p, 1);
    rd(3'd6, v);
    chk("R5 flag reg", v, 2);
    stop();
    wr(3'd6, 8'h03);
    chk("R5 both cleared", {flag_p, flag_a}, 0);

    // R6 buffered compare write
    set_cmp(10);
    wr(3'd4, 8'h34);
    rd(3'd4, v); chk("R6 lo not yet", v, 10);
    wr(3'd1, 8'h10);
    start(0);
    repeat (100) @(negedge clk);
    rd_cnt(v, m);
    chk("R6 old compare in use", v, m % 11);
    stop();
    wr(3'd5, 8'h02);
    rd(3'd4, v); chk("R6 lo committed", v, 8'h34);
    rd(3'd5, v); chk("R6 hi committed", v, 2);
    wr(3'd5, 8'hFF);
    rd(3'd5, v); chk("R7 cmp hi upper zero", v, 3);

    // R7 coherent count read and zero upper bits
    wr(3'd1, 8'h00);
    start(0);
    repeat (600) @(negedge clk);
    rd_cnt(v, m);
    chk("R7 coherent read", v, m % 1024);
    repeat (300) @(negedge clk);
    rd(3'd3, v);
    chk("R7 shadow kept", v, (m % 1024) >> 8);
    stop();

    // R8 compare-mode pin actions, compare 20 clearing on A
    set_cmp(20);
    wr(3'd1, 8'h10);
    start(0); wait_m(30); chk("R8 none", pin, 0); stop();
    wr(3'd1, 8'h18);
    start(0); wait_m(20); chk("R8 high before", pin, 0);
    wait_m(21); chk("R8 high", pin, 1); stop();
    chk("R8 hold after stop", pin, 1);
    wr(3'd1, 8'h14);
    start(0); wait_m(20); chk("R8 low before", pin, 1);
    wait_m(21); chk("R8 low", pin, 0); stop();
    wr(3'd1, 8'h1C);
    start(0);
    wait_m(20); chk("R8 tog 20", pin, 0);
    wait_m(21); chk("R8 tog 21", pin, 1);
    wait_m(41); chk("R8 tog 41", pin, 1);
    wait_m(42); chk("R8 tog 42", pin, 0);
    wait_m(63); chk("R8 tog 63", pin, 1);
    stop();

    // R10 timer modes hold pin, flags still rise
    wr(3'd1, 8'h1E);
    wr(3'd6, 8'h03);
    start(0);
    wait_m(30); chk("R10 mode10 hold", pin, 1);
    wait_m(60); chk("R10 mode10 hold late", pin, 1);
    chk("R10 flag_a in timer", flag_a, 1);
    stop();
    wr(3'd1, 8'h1F);
    start(0);
    wait_m(45); chk("R10 mode11 hold", pin, 1);
    stop();

    // R9 PWM: compare 100, period 256
    wr(3'd1, 8'h01);
    set_cmp(100);
    start(2);
    for (int i = 0; i < 600; i++) begin
      m = cyc - e_cyc;
      chk($sformatf("R9 pwm m=%0d", m), pin, ((m % 256) < 100) ? 1 : 0);
      @(negedge clk);
    end
    stop();
    chk("R9 stopped low", pin, 0);
    set_cmp(0);
    start(1);
    for (int i = 0; i < 300; i++) begin
      chk("R9 pwm zero compare", pin, 0);
      @(negedge clk);
    end
    stop();
    set_cmp(1023);
    start(0);
    wait_m(1022); chk("R9 pwm 1022", pin, 1);
    wait_m(1023); chk("R9 pwm 1023", pin, 0);
    wait_m(1024); chk("R9 pwm wrap", pin, 1);
    stop();

    report();
  end
endmodule